// File: doc/BRIEF.md
# Operand-Addressing Byte Parser

This block sits behind an instruction-byte queue in a decoder for a byte-oriented two-operand instruction set. After the opcode byte has been decoded, the decoder pulses `start` and presents four control bits taken from that opcode:

- the direction bit;
- the operand-width bit;
- the sign-extend bit;
- a flag that says an immediate operand follows.

The parser then takes the following bytes from a valid/ready byte stream. It treats the first byte as the operand-addressing byte and splits it into a 2-bit mode, a 3-bit register field and a 3-bit register/memory field. From the mode it works out whether an address offset follows and how long that offset is. The encoding mode 00 with register/memory field 110 is a special case: it means a 16-bit absolute address with no base register.

Offset bytes arrive low byte first. The parser widens a one-byte offset to 16 bits by sign extension. If the opcode asked for an immediate, the parser collects one or two more bytes. It sizes and extends the immediate from the width and sign-extend bits. When the last byte needed has been taken, the parser raises `done` for one cycle. All decoded fields stay steady until the next accepted start. Effective-address arithmetic and opcode decoding belong to the neighbouring blocks.

Top module: `operand_byte_parser`

## Requirements
- R1: After synchronous reset, `done` and `in_ready` are low, and `mod_o`, `reg_o`, `rm_o`, `disp_o` and `imm_o` are zero.
- R2: `start` is taken only while the parser is idle. A `start` that arrives during a parse is ignored. `in_ready` is high only while a byte is awaited. Bytes offered while idle, or in the `done` cycle, are not consumed.
- R3: The first byte taken is split into `mod_o` = bits 7:6, `reg_o` = bits 5:3 and `rm_o` = bits 2:0. `reg_mode` is high exactly when `mod_o` is 11. `reg_is_src` repeats the direction bit and `word_op` repeats the width bit, as both were latched at start.
- R4: The mode sets the offset length. Mode 00 (except the R5 case) and mode 11 take no offset bytes and report `disp_o` = 0. Mode 01 takes one byte and sign-extends it to 16 bits. Mode 10 takes two bytes, low byte first.
- R5: Mode 00 with register/memory field 110 takes a two-byte offset, low byte first, and raises `direct_addr`. `direct_addr` is low for every other encoding.
- R6: With `imm_en` low, no immediate bytes are taken and `imm_o` is 0. With `imm_en` high, the width and sign-extend bits set the immediate:
  - width 0: one byte, high byte zero (for either sign-extend value);
  - width 1, sign-extend 0: two bytes, low byte first;
  - width 1, sign-extend 1: one byte, bit 7 copied into all of bits 15:8.
- R7: While `in_valid` is low and a byte is awaited, the parser waits with `in_ready` held high. The stall does not alter the result.
- R8: `done` is high for exactly one cycle: the cycle after the edge that takes the last byte needed. All outputs then hold until the next accepted `start`, which clears `disp_o` and `imm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a parse; the opcode control bits are latched with it |
| op_d | input | 1 | Direction bit of the decoded opcode |
| op_w | input | 1 | Width bit of the decoded opcode (1 = 16-bit operands) |
| op_s | input | 1 | Sign-extend bit of the decoded opcode |
| imm_en | input | 1 | An immediate operand follows the offset |
| in_valid | input | 1 | `in_data` holds a byte |
| in_data | input | BYTE_W | Instruction byte |
| in_ready | output | 1 | Parser will take `in_data` at this edge if `in_valid` is high |
| mod_o | output | 2 | Mode field |
| reg_o | output | 3 | Register field |
| rm_o | output | 3 | Register/memory field |
| reg_mode | output | 1 | Both operands are registers |
| reg_is_src | output | 1 | Register field names the source operand |
| word_op | output | 1 | 16-bit operation |
| direct_addr | output | 1 | Offset is a 16-bit absolute address |
| disp_o | output | 2*BYTE_W | Assembled, extended offset |
| imm_o | output | 2*BYTE_W | Assembled, extended immediate |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:

- `done` is a single-cycle pulse, and `in_ready` is low during it.
- The results hold in the cycle after `done`.
- A stall keeps `in_ready` high.
- At completion, register mode carries a zero offset, a mode-01 offset is sign-extended, and a byte-wide immediate has a zero high byte.

Only the bench scenarios can show:

- that the number of bytes taken matches the mode, the register/memory field and the immediate controls;
- that the bytes are placed little-endian;
- that the special direct-address encoding is recognised;
- that a `start` arriving mid-parse is ignored.

The bench does this by sweeping every addressing byte against every immediate configuration.

// File: rtl/obp_pkg.sv
package obp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODRM,
        ST_DISP_LO,
        ST_DISP_HI,
        ST_IMM_LO,
        ST_IMM_HI,
        ST_DONE
    } parse_state_t;

    localparam logic [1:0] MODE_MEM0   = 2'b00;
    localparam logic [1:0] MODE_MEM8   = 2'b01;
    localparam logic [1:0] MODE_MEM16  = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;
    localparam logic [2:0] RM_ABSOLUTE = 3'b110;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] reg_f;
        logic [2:0] rm;
    } addr_fields_t;

    typedef struct packed {
        logic dir;
        logic wide;
        logic sx;
        logic has_imm;
    } op_ctl_t;

    function automatic logic is_absolute(addr_fields_t f);
        return (f.mode == MODE_MEM0) && (f.rm == RM_ABSOLUTE);
    endfunction

    // number of offset bytes that follow the addressing byte
    function automatic logic [1:0] offset_bytes(addr_fields_t f);
        logic [1:0] n;
        case (f.mode)
            MODE_MEM0:  n = is_absolute(f) ? 2'd2 : 2'd0;
            MODE_MEM8:  n = 2'd1;
            MODE_MEM16: n = 2'd2;
            default:    n = 2'd0;
        endcase
        return n;
    endfunction

    // number of immediate bytes requested by the opcode controls
    function automatic logic [1:0] imm_bytes(op_ctl_t c);
        logic [1:0] n;
        if (!c.has_imm)
            n = 2'd0;
        else if (c.wide && !c.sx)
            n = 2'd2;
        else
            n = 2'd1;
        return n;
    endfunction

endpackage

// File: rtl/obp_field_split.sv
module obp_field_split
    import obp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    output addr_fields_t      fields,
    output logic [1:0]        off_len
);
    localparam int FIELD_W = $bits(addr_fields_t);

    always_comb begin
        fields  = addr_fields_t'(byte_in[FIELD_W-1:0]);
        off_len = offset_bytes(fields);
    end
endmodule

// File: rtl/obp_le_collector.sv
module obp_le_collector #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic                  ext_lo,
    input  logic [BYTE_W-1:0]     byte_in,
    output logic [2*BYTE_W-1:0]   word_o
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] upper_fill;

    always_comb begin
        upper_fill = ext_lo ? {BYTE_W{byte_in[BYTE_W-1]}} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word_q <= '0;
        end else if (ld_lo) begin
            word_q <= {upper_fill, byte_in};
        end else if (ld_hi) begin
            word_q[WORD_W-1:BYTE_W] <= byte_in;
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/obp_parse_ctrl.sv
module obp_parse_ctrl
    import obp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         in_valid,
    input  logic [1:0]   off_len_now,
    input  logic [1:0]   imm_len,
    output parse_state_t state,
    output logic         start_acc,
    output logic         take,
    output logic         in_ready,
    output logic         done
);
    parse_state_t state_q, state_n;
    logic [1:0]   off_len_q;

    always_comb begin
        in_ready  = (state_q == ST_MODRM)   || (state_q == ST_DISP_LO) ||
                    (state_q == ST_DISP_HI) || (state_q == ST_IMM_LO)  ||
                    (state_q == ST_IMM_HI);
        take      = in_ready && in_valid;
        start_acc = (state_q == ST_IDLE) && start;
        done      = (state_q == ST_DONE);
    end

    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_IDLE: if (start) state_n = ST_MODRM;
            ST_MODRM: if (take) begin
                if (off_len_now != 2'd0)  state_n = ST_DISP_LO;
                else if (imm_len != 2'd0) state_n = ST_IMM_LO;
                else                      state_n = ST_DONE;
            end
            ST_DISP_LO: if (take) begin
                if (off_len_q == 2'd2)    state_n = ST_DISP_HI;
                else if (imm_len != 2'd0) state_n = ST_IMM_LO;
                else                      state_n = ST_DONE;
            end
            ST_DISP_HI: if (take) begin
                state_n = (imm_len != 2'd0) ? ST_IMM_LO : ST_DONE;
            end
            ST_IMM_LO: if (take) begin
                state_n = (imm_len == 2'd2) ? ST_IMM_HI : ST_DONE;
            end
            ST_IMM_HI: if (take) state_n = ST_DONE;
            ST_DONE:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            off_len_q <= 2'd0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_MODRM && take)
                off_len_q <= off_len_now;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/operand_byte_parser.sv
module operand_byte_parser
    import obp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                op_d,
    input  logic                op_w,
    input  logic                op_s,
    input  logic                imm_en,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                in_ready,
    output logic [1:0]          mod_o,
    output logic [2:0]          reg_o,
    output logic [2:0]          rm_o,
    output logic                reg_mode,
    output logic                reg_is_src,
    output logic                word_op,
    output logic                direct_addr,
    output logic [2*BYTE_W-1:0] disp_o,
    output logic [2*BYTE_W-1:0] imm_o,
    output logic                done
);
    localparam int WORD_W = 2 * BYTE_W;

    parse_state_t state;
    logic         start_acc, take;
    addr_fields_t fields_now, fields_q;
    logic [1:0]   off_len_now, imm_len;
    op_ctl_t      ctl_q;

    obp_field_split #(.BYTE_W(BYTE_W)) u_split (
        .byte_in (in_data),
        .fields  (fields_now),
        .off_len (off_len_now)
    );

    always_comb imm_len = imm_bytes(ctl_q);

    obp_parse_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .in_valid    (in_valid),
        .off_len_now (off_len_now),
        .imm_len     (imm_len),
        .state       (state),
        .start_acc   (start_acc),
        .take        (take),
        .in_ready    (in_ready),
        .done        (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            fields_q <= '0;
        end else if (start_acc) begin
            ctl_q    <= '{dir: op_d, wide: op_w, sx: op_s, has_imm: imm_en};
            fields_q <= '0;
        end else if (state == ST_MODRM && take) begin
            fields_q <= fields_now;
        end
    end

    logic [WORD_W-1:0] disp_w, imm_w;

    obp_le_collector #(.BYTE_W(BYTE_W)) u_disp (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_acc),
        .ld_lo   (take && state == ST_DISP_LO),
        .ld_hi   (take && state == ST_DISP_HI),
        .ext_lo  (fields_q.mode == MODE_MEM8),
        .byte_in (in_data),
        .word_o  (disp_w)
    );

    obp_le_collector #(.BYTE_W(BYTE_W)) u_imm (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_acc),
        .ld_lo   (take && state == ST_IMM_LO),
        .ld_hi   (take && state == ST_IMM_HI),
        .ext_lo  (ctl_q.sx && ctl_q.wide),
        .byte_in (in_data),
        .word_o  (imm_w)
    );

    always_comb begin
        mod_o       = fields_q.mode;
        reg_o       = fields_q.reg_f;
        rm_o        = fields_q.rm;
        reg_mode    = (fields_q.mode == MODE_REG);
        direct_addr = is_absolute(fields_q);
        reg_is_src  = ctl_q.dir;
        word_op     = ctl_q.wide;
        disp_o      = disp_w;
        imm_o       = imm_w;
    end
endmodule

// File: rtl/obp_checker.sv
module obp_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [1:0]          mod_o,
    input logic                reg_mode,
    input logic                word_op,
    input logic [2*BYTE_W-1:0] disp_o,
    input logic [2*BYTE_W-1:0] imm_o,
    input logic                done
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    hold_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(disp_o) && $stable(imm_o) && $stable(mod_o)));

    // R2
    no_ready_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R7
    stall_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

    // R4
    reg_mode_no_disp_chk: assert property (@(posedge clk) disable iff (rst)
        (done && reg_mode) |-> (disp_o == '0));

    // R4
    disp8_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (done && mod_o == 2'b01) |-> (disp_o[2*BYTE_W-1:BYTE_W] == {BYTE_W{disp_o[BYTE_W-1]}}));

    // R6
    byte_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !word_op) |-> (imm_o[2*BYTE_W-1:BYTE_W] == '0));
endmodule

bind operand_byte_parser obp_checker #(.BYTE_W(BYTE_W)) u_obp_chk (.*);

// File: tb/operand_byte_parser_test.sv
module operand_byte_parser_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, op_d = 1'b0, op_w = 1'b0, op_s = 1'b0, imm_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic [1:0]  mod_o;
    logic [2:0]  reg_o, rm_o;
    logic        reg_mode, reg_is_src, word_op, direct_addr, done;
    logic [15:0] disp_o, imm_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    operand_byte_parser uut (
        .clk(clk), .rst(rst), .start(start), .op_d(op_d), .op_w(op_w),
        .op_s(op_s), .imm_en(imm_en), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mod_o(mod_o), .reg_o(reg_o), .rm_o(rm_o),
        .reg_mode(reg_mode), .reg_is_src(reg_is_src), .word_op(word_op),
        .direct_addr(direct_addr), .disp_o(disp_o), .imm_o(imm_o), .done(done)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sx8(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    // offer one byte, optionally after a stall; called and returns at a negedge
    task automatic send_byte(input logic [7:0] b, input bit stall);
        bit ok = 1'b0;
        if (stall) begin
            in_valid = 1'b0;
            @(negedge clk);
            check("R7 ready held in stall", {15'd0, in_ready}, 16'd1);
        end
        in_data  = b;
        in_valid = 1'b1;
        for (int i = 0; i < 20; i++) begin
            ok = in_ready;
            @(negedge clk);
            if (ok) break;
        end
        if (!ok) check("R2 byte not taken", 16'd0, 16'd1);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start(input bit d, input bit w, input bit s, input bit ie);
        op_d = d; op_w = w; op_s = s; imm_en = ie;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_one(input logic [7:0] b, input int cfg);
        bit ie, w, s, d, stall;
        int dl, il;
        logic [7:0] d0, d1, i0, i1;
        logic [15:0] edisp, eimm;
        logic [15:0] hold_d;
        ie = (cfg >= 2);
        w  = (cfg == 1) || (cfg == 3) || (cfg == 4);
        s  = (cfg == 4) || (cfg == 5);
        d  = b[0] ^ b[3];
        d0 = b ^ 8'hA5; d1 = b + 8'd1; i0 = ~b; i1 = b ^ 8'h3C;
        if (b[7:6] == 2'b00 && b[2:0] == 3'b110) dl = 2;
        else if (b[7:6] == 2'b01) dl = 1;
        else if (b[7:6] == 2'b10) dl = 2;
        else dl = 0;
        il = !ie ? 0 : (w && !s) ? 2 : 1;
        edisp = (dl == 0) ? 16'h0 : (dl == 1) ? sx8(d0) : {d1, d0};
        eimm  = (il == 0) ? 16'h0 : (il == 2) ? {i1, i0} : (w && s) ? sx8(i0) : {8'h00, i0};
        stall = (((int'(b) + cfg) % 3) == 0);

        pulse_start(d, w, s, ie);
        send_byte(b, stall);
        if (dl >= 1) send_byte(d0, 1'b0);
        if (dl == 2) send_byte(d1, stall);
        if (il >= 1) send_byte(i0, stall);
        if (il == 2) send_byte(i1, 1'b0);

        check("R8 done after last byte", {15'd0, done}, 16'd1);
        check("R2 ready low at done", {15'd0, in_ready}, 16'd0);
        check("R3 fields", {8'd0, mod_o, reg_o, rm_o}, {8'd0, b});
        check("R3 flags", {13'd0, reg_mode, reg_is_src, word_op},
              {13'd0, (b[7:6] == 2'b11), d, w});
        check("R5 direct flag", {15'd0, direct_addr},
              {15'd0, (b[7:6] == 2'b00 && b[2:0] == 3'b110)});
        check(dl == 2 && b[7:6] == 2'b00 ? "R5 direct offset" : "R4 offset", disp_o, edisp);
        check("R6 immediate", imm_o, eimm);
        hold_d = disp_o;
        @(negedge clk);
        check("R8 single pulse", {15'd0, done}, 16'd0);
        check("R8 hold", disp_o, hold_d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 done", {15'd0, done}, 16'd0);
        check("R1 ready", {15'd0, in_ready}, 16'd0);
        check("R1 fields", {8'd0, mod_o, reg_o, rm_o}, 16'd0);
        check("R1 disp", disp_o, 16'd0);
        check("R1 imm", imm_o, 16'd0);

        // R2 bytes offered while idle are not consumed
        in_valid = 1'b1; in_data = 8'hC7;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 idle ignores byte", {15'd0, in_ready}, 16'd0);
        end
        in_valid = 1'b0;
        check("R2 idle fields untouched", {8'd0, mod_o, reg_o, rm_o}, 16'd0);

        // R2 start during a parse is ignored
        pulse_start(1'b1, 1'b1, 1'b0, 1'b0);
        send_byte(8'h85, 1'b0);
        pulse_start(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 busy start ignored ready", {15'd0, in_ready}, 16'd1);
        send_byte(8'h34, 1'b0);
        send_byte(8'h12, 1'b0);
        check("R2 busy start done", {15'd0, done}, 16'd1);
        check("R2 busy start disp", disp_o, 16'h1234);
        check("R2 busy start width kept", {15'd0, word_op}, 16'd1);
        @(negedge clk);

        // exhaustive sweep of addressing bytes against immediate configurations
        for (int cfg = 0; cfg < 6; cfg++)
            for (int b = 0; b < 256; b++)
                run_one(8'(b), cfg);

        // R8 next start clears offset and immediate
        pulse_start(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 start clears disp", disp_o, 16'd0);
        check("R8 start clears imm", imm_o, 16'd0);
        send_byte(8'hC0, 1'b0);
        check("R8 done reg form", {15'd0, done}, 16'd1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule